// File: doc/BRIEF.md
# PHY PLL Power Sequencer

This block is a small hardware state machine that owns the enable bits of a video transmitter PHY's PLL and TMDS output stage. The host sends one command at a time: bring the PLL up, take it down, switch the TMDS lanes on or off, or load a new rate. The block then applies the enable bits one step per clock. Fixed settle waits between some steps are counted in reference clock cycles. Teardown runs the bring-up steps in reverse.

A set-rate command reads a requested pixel rate in kHz and latches the settings for that rate. These are the pre-divider, the TX divider, the parent-clock halving flag, the per-lane pre-driver bias, the per-lane driver impedance enables and the per-lane driver bias. The command also latches a set of fixed loop-filter values. Every control output is a register, so the image can drive the analog macro directly. The block raises `busy` while a command is in progress. Commands that arrive while it is busy are ignored.

Top module: `pll_pwr_seq`

## Requirements
- R1: A synchronous active-high `rst` clears every control output to zero, clears the TMDS enables and drives `busy` low. This holds even in the middle of a sequence.
- R2: Prepare (`cmd_op`=1) takes W = REF_CLK_MHZ*SETTLE_US cycles per wait. Counting the accept edge as edge 0, the steps land on these edges:
  - `calib_en` is set on edge 1.
  - `postdiv` is set to 3 on edge 2.
  - `lane_clk_en` is cleared on edge 3.
  - `bias_en` is set on edge 4.
  - `pll_en` is set on edge 5+W.
  - `lpf_bias_en` is set on edge 6+2W.
  - `txdiv_en` is set on edge 7+2W.
- R3: Unprepare (`cmd_op`=2) clears the enables on these edges:
  - `txdiv_en` on edge 1.
  - `lpf_bias_en` on edge 2.
  - `pll_en` on edge 3+W.
  - `bias_en` on edge 4+2W.
  - `postdiv` on edge 5+2W.
  - `calib_en` on edge 6+2W.
  - A final wait then ends the command on edge 6+3W.
- R4: TMDS on (`cmd_op`=3) sets `ser_en`, `prd_en` and `drv_en` to all ones on edge 1, then waits W cycles and ends on edge 1+W. TMDS off (`cmd_op`=4) clears all three on edge 1 and ends on the same edge.
- R5: Set-rate (`cmd_op`=5) latches `prediv`, `txdiv` and `parent_half` on edge 1, chosen from the rate:
  - At or below 27000 kHz: 0/3/0.
  - At or below 74250 kHz: 1/2/0.
  - Above 74250 kHz: 1/1/1.
- R6: Set-rate chooses the lane settings from the rate:
  - Below 165000 kHz: every 4-bit lane field of `prd_ibias` is 3, `imp_en` is 0, and every 6-bit lane field of `drv_ibias` equals `drv_bias_lo`.
  - At or above 165000 kHz: the fields are 6, `imp_en` is all ones, and `drv_bias_hi` is used.
- R7: Set-rate sets `postdiv` to 3 and loads `loop_cfg` with these fixed values:
  - [27:21]=19
  - [20:19]=1
  - [18:16]=2
  - [15:12]=1
  - [11:8]=1
  - [7:4]=0xC
  - [3:2]=1
  - [1:0]=2
- R8: `busy` is high from the edge that accepts a command until the edge of its last step. A set-rate command holds it high for exactly one cycle.
- R9: A command that arrives while `busy` is high has no effect. An op code outside 1..5 also has no effect, and `busy` stays low after it.
- R10: A set-rate command is ignored while `pll_en` is high. The latched rate settings stay unchanged.
- R11: `pll_en` high implies `bias_en` high. `txdiv_en` high implies both `pll_en` and `lpf_bias_en` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, sampled when idle |
| cmd_op | input | 3 | 1 prepare, 2 unprepare, 3 TMDS on, 4 TMDS off, 5 set-rate |
| rate_khz | input | RATE_W | Requested rate in kHz for set-rate |
| drv_bias_lo | input | BIAS_W | Driver bias used below the high-rate threshold |
| drv_bias_hi | input | BIAS_W | Driver bias used at or above the high-rate threshold |
| busy | output | 1 | Command in progress |
| calib_en | output | 1 | Auto-calibration enable |
| postdiv | output | 2 | Post-divider field |
| bias_en | output | 1 | PLL bias enable |
| pll_en | output | 1 | PLL enable |
| lpf_bias_en | output | 1 | Loop-filter bias enable |
| txdiv_en | output | 1 | TX divider enable |
| lane_clk_en | output | 1 | Lane clock enable |
| prediv | output | 2 | Latched pre-divider |
| txdiv | output | 2 | Latched TX divider |
| parent_half | output | 1 | Parent clock is half the requested rate |
| loop_cfg | output | 28 | Fixed loop-filter and feedback values |
| prd_ibias | output | LANES*4 | Pre-driver bias per lane |
| imp_en | output | LANES | Driver impedance enable per lane |
| drv_ibias | output | LANES*BIAS_W | Driver bias per lane |
| ser_en | output | LANES | Serializer enable per lane |
| prd_en | output | LANES | Pre-driver enable per lane |
| drv_en | output | LANES | Driver enable per lane |

## Verification
The bench builds the block with REF_CLK_MHZ=2 and SETTLE_US=5. This gives a settle wait of 10 cycles, so the longest sequence, unprepare, ends 36 cycles after acceptance. At that length every step edge can be timed exactly and compared against the requirement formulas. The rate thresholds keep their default values. This lets the vector table probe the exact boundary rates and the rates one kHz on either side.

// File: rtl/pll_pwr_seq_pkg.sv
package pll_pwr_seq_pkg;

  localparam logic [2:0] OP_PREP     = 3'd1;
  localparam logic [2:0] OP_UNPREP   = 3'd2;
  localparam logic [2:0] OP_TMDS_ON  = 3'd3;
  localparam logic [2:0] OP_TMDS_OFF = 3'd4;
  localparam logic [2:0] OP_RATE     = 3'd5;

  localparam int PRD_W  = 4;
  localparam int LOOP_W = 28;

  // feedback div, feedback sel, divider enable, cp current, resistor, bp, br, bc
  localparam logic [LOOP_W-1:0] LOOP_FIXED =
    {7'd19, 2'd1, 3'd2, 4'd1, 4'd1, 4'hC, 2'd1, 2'd2};

  typedef enum logic [4:0] {
    S_IDLE,
    S_P_CAL, S_P_POST, S_P_LANE, S_P_BIAS, S_P_W1, S_P_PLL, S_P_W2, S_P_LPF, S_P_TXD,
    S_U_TXD, S_U_LPF, S_U_W1, S_U_PLL, S_U_W2, S_U_BIAS, S_U_POST, S_U_CAL, S_U_W3,
    S_T_ON, S_T_W, S_T_OFF,
    S_RATE
  } seq_state_e;

endpackage

// File: rtl/pll_settle_timer.sv
module pll_settle_timer #(
  parameter int WAIT_CYC = 2700
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(WAIT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WAIT_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign done = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || done) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  // R2
  wait_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

endmodule

// File: rtl/pll_rate_decode.sv
module pll_rate_decode #(
  parameter int RATE_W  = 20,
  parameter int LANES   = 4,
  parameter int BIAS_W  = 6,
  parameter int LOW_KHZ = 27000,
  parameter int MID_KHZ = 74250,
  parameter int HI_KHZ  = 165000
) (
  input  logic [RATE_W-1:0]       rate_khz,
  input  logic [BIAS_W-1:0]       bias_lo,
  input  logic [BIAS_W-1:0]       bias_hi,
  output logic [1:0]              prediv,
  output logic [1:0]              txdiv,
  output logic                    parent_half,
  output logic [LANES*pll_pwr_seq_pkg::PRD_W-1:0] prd_ibias,
  output logic [LANES-1:0]        imp_en,
  output logic [LANES*BIAS_W-1:0] drv_ibias
);
  import pll_pwr_seq_pkg::*;

  localparam logic [RATE_W-1:0] LOW_T = RATE_W'(LOW_KHZ);
  localparam logic [RATE_W-1:0] MID_T = RATE_W'(MID_KHZ);
  localparam logic [RATE_W-1:0] HI_T  = RATE_W'(HI_KHZ);

  logic high_band;

  always_comb begin
    if (rate_khz <= LOW_T) begin
      prediv = 2'd0;
      txdiv  = 2'd3;
    end else if (rate_khz <= MID_T) begin
      prediv = 2'd1;
      txdiv  = 2'd2;
    end else begin
      prediv = 2'd1;
      txdiv  = 2'd1;
    end
    parent_half = (rate_khz > MID_T);
    high_band   = (rate_khz >= HI_T);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign prd_ibias[l*PRD_W +: PRD_W]   = high_band ? PRD_W'(6) : PRD_W'(3);
    assign imp_en[l]                     = high_band;
    assign drv_ibias[l*BIAS_W +: BIAS_W] = high_band ? bias_hi : bias_lo;
  end

endmodule

// File: rtl/pll_pwr_seq.sv
module pll_pwr_seq
  import pll_pwr_seq_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int RATE_W      = 20,
  parameter int BIAS_W      = 6,
  parameter int REF_CLK_MHZ = 27,
  parameter int SETTLE_US   = 100,
  parameter int LOW_KHZ     = 27000,
  parameter int MID_KHZ     = 74250,
  parameter int HI_KHZ      = 165000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cmd_valid,
  input  logic [2:0]              cmd_op,
  input  logic [RATE_W-1:0]       rate_khz,
  input  logic [BIAS_W-1:0]       drv_bias_lo,
  input  logic [BIAS_W-1:0]       drv_bias_hi,
  output logic                    busy,
  output logic                    calib_en,
  output logic [1:0]              postdiv,
  output logic                    bias_en,
  output logic                    pll_en,
  output logic                    lpf_bias_en,
  output logic                    txdiv_en,
  output logic                    lane_clk_en,
  output logic [1:0]              prediv,
  output logic [1:0]              txdiv,
  output logic                    parent_half,
  output logic [27:0]             loop_cfg,
  output logic [LANES*4-1:0]      prd_ibias,
  output logic [LANES-1:0]        imp_en,
  output logic [LANES*BIAS_W-1:0] drv_ibias,
  output logic [LANES-1:0]        ser_en,
  output logic [LANES-1:0]        prd_en,
  output logic [LANES-1:0]        drv_en
);
  localparam int WAIT_CYC = REF_CLK_MHZ * SETTLE_US;

  seq_state_e st_q;
  logic in_wait, wait_done;

  logic [1:0]              d_prediv, d_txdiv;
  logic                    d_half;
  logic [LANES*4-1:0]      d_prd;
  logic [LANES-1:0]        d_imp;
  logic [LANES*BIAS_W-1:0] d_drv;

  pll_rate_decode #(
    .RATE_W(RATE_W), .LANES(LANES), .BIAS_W(BIAS_W),
    .LOW_KHZ(LOW_KHZ), .MID_KHZ(MID_KHZ), .HI_KHZ(HI_KHZ)
  ) dec_i (
    .rate_khz(rate_khz), .bias_lo(drv_bias_lo), .bias_hi(drv_bias_hi),
    .prediv(d_prediv), .txdiv(d_txdiv), .parent_half(d_half),
    .prd_ibias(d_prd), .imp_en(d_imp), .drv_ibias(d_drv)
  );

  always_comb begin
    in_wait = (st_q == S_P_W1) || (st_q == S_P_W2) || (st_q == S_U_W1) ||
              (st_q == S_U_W2) || (st_q == S_U_W3) || (st_q == S_T_W);
  end

  pll_settle_timer #(.WAIT_CYC(WAIT_CYC)) tmr_i (
    .clk(clk), .rst(rst), .run(in_wait), .done(wait_done)
  );

  assign busy = (st_q != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= S_IDLE;
      calib_en    <= 1'b0;
      postdiv     <= 2'd0;
      bias_en     <= 1'b0;
      pll_en      <= 1'b0;
      lpf_bias_en <= 1'b0;
      txdiv_en    <= 1'b0;
      lane_clk_en <= 1'b0;
      prediv      <= 2'd0;
      txdiv       <= 2'd0;
      parent_half <= 1'b0;
      loop_cfg    <= '0;
      prd_ibias   <= '0;
      imp_en      <= '0;
      drv_ibias   <= '0;
      ser_en      <= '0;
      prd_en      <= '0;
      drv_en      <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (cmd_valid) begin
          case (cmd_op)
            OP_PREP:     st_q <= S_P_CAL;
            OP_UNPREP:   st_q <= S_U_TXD;
            OP_TMDS_ON:  st_q <= S_T_ON;
            OP_TMDS_OFF: st_q <= S_T_OFF;
            OP_RATE:     if (!pll_en) st_q <= S_RATE;
            default:     ;
          endcase
        end
        // bring-up
        S_P_CAL:  begin calib_en    <= 1'b1; st_q <= S_P_POST; end
        S_P_POST: begin postdiv     <= 2'd3; st_q <= S_P_LANE; end
        S_P_LANE: begin lane_clk_en <= 1'b0; st_q <= S_P_BIAS; end
        S_P_BIAS: begin bias_en     <= 1'b1; st_q <= S_P_W1;   end
        S_P_W1:   if (wait_done) st_q <= S_P_PLL;
        S_P_PLL:  begin pll_en      <= 1'b1; st_q <= S_P_W2;   end
        S_P_W2:   if (wait_done) st_q <= S_P_LPF;
        S_P_LPF:  begin lpf_bias_en <= 1'b1; st_q <= S_P_TXD;  end
        S_P_TXD:  begin txdiv_en    <= 1'b1; st_q <= S_IDLE;   end
        // teardown
        S_U_TXD:  begin txdiv_en    <= 1'b0; st_q <= S_U_LPF;  end
        S_U_LPF:  begin lpf_bias_en <= 1'b0; st_q <= S_U_W1;   end
        S_U_W1:   if (wait_done) st_q <= S_U_PLL;
        S_U_PLL:  begin pll_en      <= 1'b0; st_q <= S_U_W2;   end
        S_U_W2:   if (wait_done) st_q <= S_U_BIAS;
        S_U_BIAS: begin bias_en     <= 1'b0; st_q <= S_U_POST; end
        S_U_POST: begin postdiv     <= 2'd0; st_q <= S_U_CAL;  end
        S_U_CAL:  begin calib_en    <= 1'b0; st_q <= S_U_W3;   end
        S_U_W3:   if (wait_done) st_q <= S_IDLE;
        // output stage
        S_T_ON: begin
          ser_en <= '1; prd_en <= '1; drv_en <= '1;
          st_q <= S_T_W;
        end
        S_T_W:  if (wait_done) st_q <= S_IDLE;
        S_T_OFF: begin
          ser_en <= '0; prd_en <= '0; drv_en <= '0;
          st_q <= S_IDLE;
        end
        // rate load
        S_RATE: begin
          prediv      <= d_prediv;
          txdiv       <= d_txdiv;
          parent_half <= d_half;
          prd_ibias   <= d_prd;
          imp_en      <= d_imp;
          drv_ibias   <= d_drv;
          loop_cfg    <= LOOP_FIXED;
          postdiv     <= 2'd3;
          st_q        <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R11
  pll_needs_bias_chk: assert property (@(posedge clk) disable iff (rst)
    pll_en |-> bias_en);

  // R11
  txdiv_needs_pll_chk: assert property (@(posedge clk) disable iff (rst)
    txdiv_en |-> (pll_en && lpf_bias_en));

  // R10
  rate_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    pll_en |=> $stable(prediv) && $stable(txdiv));

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && cmd_valid && cmd_op == OP_PREP) |=> busy);

endmodule

// File: tb/pll_pwr_seq_tb.sv
`timescale 1ns/1ps
module pll_pwr_seq_tb_top;
  localparam int LANES = 4;
  localparam int RATE_W = 20;
  localparam int BIAS_W = 6;
  localparam int W = 10;  // 2 MHz * 5 us

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [RATE_W-1:0] rate_khz = '0;
  logic [BIAS_W-1:0] b_lo = 6'h15, b_hi = 6'h2A;
  logic busy, calib_en, bias_en, pll_en, lpf_bias_en, txdiv_en, lane_clk_en, parent_half;
  logic [1:0] postdiv, prediv, txdiv;
  logic [27:0] loop_cfg;
  logic [LANES*4-1:0] prd_ibias;
  logic [LANES-1:0] imp_en, ser_en, prd_en, drv_en;
  logic [LANES*BIAS_W-1:0] drv_ibias;

  always #5 clk = ~clk;

  pll_pwr_seq #(.LANES(LANES), .RATE_W(RATE_W), .BIAS_W(BIAS_W),
                .REF_CLK_MHZ(2), .SETTLE_US(5)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .rate_khz(rate_khz), .drv_bias_lo(b_lo), .drv_bias_hi(b_hi),
    .busy(busy), .calib_en(calib_en), .postdiv(postdiv), .bias_en(bias_en),
    .pll_en(pll_en), .lpf_bias_en(lpf_bias_en), .txdiv_en(txdiv_en),
    .lane_clk_en(lane_clk_en), .prediv(prediv), .txdiv(txdiv),
    .parent_half(parent_half), .loop_cfg(loop_cfg), .prd_ibias(prd_ibias),
    .imp_en(imp_en), .drv_ibias(drv_ibias), .ser_en(ser_en), .prd_en(prd_en),
    .drv_en(drv_en)
  );

  int n_chk = 0, n_fail = 0;
  int t_cal, t_post, t_bias, t_pll, t_lpf, t_txd, t_ser, t_busy;

  // rate[25:6] prediv[5:4] txdiv[3:2] half[1] high[0]
  localparam logic [25:0] RV [8] = '{
    {20'd25000,  2'd0, 2'd3, 1'b0, 1'b0},
    {20'd27000,  2'd0, 2'd3, 1'b0, 1'b0},
    {20'd27001,  2'd1, 2'd2, 1'b0, 1'b0},
    {20'd74250,  2'd1, 2'd2, 1'b0, 1'b0},
    {20'd74251,  2'd1, 2'd1, 1'b1, 1'b0},
    {20'd164999, 2'd1, 2'd1, 1'b1, 1'b0},
    {20'd165000, 2'd1, 2'd1, 1'b1, 1'b1},
    {20'd297000, 2'd1, 2'd1, 1'b1, 1'b1}
  };
  localparam logic [27:0] LOOP_EXP = {7'd19, 2'd1, 3'd2, 4'd1, 4'd1, 4'hC, 2'd1, 2'd2};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op);
    cmd_op = op; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic trace();
    logic p_cal, p_bias, p_pll, p_lpf, p_txd;
    logic [1:0] p_post;
    logic [LANES-1:0] p_ser;
    int n;
    t_cal = -1; t_post = -1; t_bias = -1; t_pll = -1; t_lpf = -1; t_txd = -1; t_ser = -1;
    p_cal = calib_en; p_post = postdiv; p_bias = bias_en; p_pll = pll_en;
    p_lpf = lpf_bias_en; p_txd = txdiv_en; p_ser = ser_en;
    n = 0;
    while (busy && n < 1000) begin
      @(negedge clk); n++;
      if (t_cal  < 0 && calib_en    != p_cal ) t_cal  = n;
      if (t_post < 0 && postdiv     != p_post) t_post = n;
      if (t_bias < 0 && bias_en     != p_bias) t_bias = n;
      if (t_pll  < 0 && pll_en      != p_pll ) t_pll  = n;
      if (t_lpf  < 0 && lpf_bias_en != p_lpf ) t_lpf  = n;
      if (t_txd  < 0 && txdiv_en    != p_txd ) t_txd  = n;
      if (t_ser  < 0 && ser_en      != p_ser ) t_ser  = n;
    end
    t_busy = n;
  endtask

  task automatic chk_reset_state(input string req);
    chk(req, {busy, calib_en, postdiv, bias_en, pll_en, lpf_bias_en, txdiv_en, lane_clk_en}, '0);
    chk(req, {prediv, txdiv, parent_half, loop_cfg}, '0);
    chk(req, {prd_ibias, imp_en, drv_ibias}, '0);
    chk(req, {ser_en, prd_en, drv_en}, '0);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_reset_state("R1");

    // R2 prepare order and timing
    issue(pll_pwr_seq_pkg::OP_PREP);
    chk("R8 busy on accept", busy, 1);
    trace();
    chk("R2 calib edge", t_cal, 1);
    chk("R2 postdiv edge", t_post, 2);
    chk("R2 bias edge", t_bias, 4);
    chk("R2 pll edge", t_pll, 5 + W);
    chk("R2 lpf edge", t_lpf, 6 + 2*W);
    chk("R2 txdiv edge", t_txd, 7 + 2*W);
    chk("R8 prepare end", t_busy, 7 + 2*W);
    chk("R2 final", {calib_en, postdiv, bias_en, pll_en, lpf_bias_en, txdiv_en, lane_clk_en}, 8'b1111_1110);

    // R10 set-rate ignored while prepared
    rate_khz = 20'd300000;
    issue(pll_pwr_seq_pkg::OP_RATE);
    chk("R10 no busy", busy, 0);
    chk("R10 rate untouched", {prediv, txdiv, parent_half, imp_en}, '0);

    // R3 unprepare order and timing
    issue(pll_pwr_seq_pkg::OP_UNPREP);
    trace();
    chk("R3 txdiv edge", t_txd, 1);
    chk("R3 lpf edge", t_lpf, 2);
    chk("R3 pll edge", t_pll, 3 + W);
    chk("R3 bias edge", t_bias, 4 + 2*W);
    chk("R3 postdiv edge", t_post, 5 + 2*W);
    chk("R3 calib edge", t_cal, 6 + 2*W);
    chk("R8 unprepare end", t_busy, 6 + 3*W);
    chk("R3 final", {calib_en, postdiv, bias_en, pll_en, lpf_bias_en, txdiv_en}, '0);

    // R5 R6 R7 rate table
    for (int i = 0; i < 8; i++) begin
      rate_khz = RV[i][25:6];
      issue(pll_pwr_seq_pkg::OP_RATE);
      trace();
      chk("R8 rate busy one cycle", t_busy, 1);
      chk("R5 prediv", prediv, RV[i][5:4]);
      chk("R5 txdiv", txdiv, RV[i][3:2]);
      chk("R5 parent_half", parent_half, RV[i][1]);
      chk("R6 prd_ibias", prd_ibias, RV[i][0] ? {LANES{4'd6}} : {LANES{4'd3}});
      chk("R6 imp_en", imp_en, RV[i][0] ? {LANES{1'b1}} : {LANES{1'b0}});
      chk("R6 drv_ibias", drv_ibias, RV[i][0] ? {LANES{b_hi}} : {LANES{b_lo}});
      chk("R7 loop_cfg", loop_cfg, LOOP_EXP);
      chk("R7 postdiv", postdiv, 2'd3);
    end

    // R9 unknown op codes
    issue(3'd0);
    chk("R9 op0 ignored", busy, 0);
    issue(3'd7);
    chk("R9 op7 ignored", busy, 0);

    // R4 TMDS on then off
    issue(pll_pwr_seq_pkg::OP_TMDS_ON);
    trace();
    chk("R4 on edge", t_ser, 1);
    chk("R4 on end", t_busy, 1 + W);
    chk("R4 on value", {ser_en, prd_en, drv_en}, {3*LANES{1'b1}});
    issue(pll_pwr_seq_pkg::OP_TMDS_OFF);
    trace();
    chk("R4 off edge", t_ser, 1);
    chk("R4 off end", t_busy, 1);
    chk("R4 off value", {ser_en, prd_en, drv_en}, '0);

    // R9 set-rate during TMDS wait is ignored (last table rate was high band)
    issue(pll_pwr_seq_pkg::OP_TMDS_ON);
    @(negedge clk);
    rate_khz = 20'd20000;
    issue(pll_pwr_seq_pkg::OP_RATE);
    trace();
    chk("R9 rate while busy prediv", prediv, 2'd1);
    chk("R9 rate while busy imp", imp_en, {LANES{1'b1}});

    // R9 unprepare during prepare is ignored
    issue(pll_pwr_seq_pkg::OP_PREP);
    repeat (3) @(negedge clk);
    issue(pll_pwr_seq_pkg::OP_UNPREP);
    trace();
    chk("R9 prepare completes", {bias_en, pll_en, lpf_bias_en, txdiv_en}, 4'hF);
    chk("R9 stays idle", busy, 0);

    // R1 reset in the middle of unprepare
    issue(pll_pwr_seq_pkg::OP_UNPREP);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk_reset_state("R1 mid-sequence");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule